// File: doc/BRIEF.md
# Steerable Peripheral Interrupt Collector

This block sits between a peripheral bus core and a host microcontroller that has two interrupt request inputs. Six event sources from the core raise single-cycle pulses: being selected or reselected, completion of a DMA transfer, a reset seen on the bus, a parity error during a data transfer, a phase mismatch, and a disconnection. Each pulse sets a sticky pending bit. Each pending bit passes through a per-source enable mask. A per-source steering bit then sends it to request line 0 or request line 1.

The host reaches four 8-bit registers over a small synchronous register port. The registers are the pending status, the mask, the steering select and a global enable. Reading the pending status returns its contents and clears every pending bit on the same clock edge. An event that arrives on that same edge survives the clear.

A DMA completion in the receive direction is held back until the core reports that its buffer is empty and that no handshake is still in flight. Only then does it become pending.

Top module: `irq_steer`

## Requirements
- R1: A pulse on `evt_i[k]` sets pending bit k, which stays set until cleared. The bit positions are: 0 selection/reselection, 1 DMA completion, 2 bus reset, 3 parity error, 4 phase mismatch, 5 disconnection.
- R2: A read at offset 0 returns the pending bits in `rdata_o[5:0]`, with zeros in bits 7:6. The read clears all pending bits at that clock edge. Reads at offsets 1, 2 and 3 leave the pending bits unchanged.
- R3: An event pulse in the same cycle as a clearing status read remains pending after the read.
- R4: A mask bit of 0 (offset 1, bit k) keeps source k from driving either request output. A mask bit of 1 lets it through.
- R5: A steering bit of 0 (offset 2, bit k) sends unmasked pending source k to `irq_o[0]`. A steering bit of 1 sends it to `irq_o[1]`. Each output is the OR of the sources routed to it.
- R6: When enable bit 0 at offset 3 is 0, both outputs stay low, and pending bits are still recorded.
- R7: The outputs are active-high and registered. They reflect register and pending state one clock edge after that state changes.
- R8: A DMA completion pulse with `dma_rx_i` high becomes pending only once `buf_empty_i` is 1 and `hs_busy_i` is 0. If these conditions already hold, it becomes pending at once. A completion pulse with `dma_rx_i` low becomes pending at once.
- R9: All registers reset to 0. Offsets 1 and 2 store bits 5:0, offset 3 stores bit 0, and unused bits read as 0.
- R10: Writes to offset 0 have no effect on the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Single-cycle event pulses, one per source |
| dma_rx_i | input | 1 | Direction of the DMA completion pulse: 1 = receive |
| buf_empty_i | input | 1 | Core data buffer holds no data |
| hs_busy_i | input | 1 | Core handshake still in progress |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 2 | Interrupt request lines 0 and 1 |

## Verification
The bench sets all six sources pending and sweeps every combination of mask and steering values. A swapped steering polarity or a mask that leaks would light the wrong line, or a line with nothing routed to it.

It fires an event into the exact cycle of a status read. A design that applies the clear after the set would lose that event.

It holds a receive-direction completion while the buffer still holds data, and again while a handshake is outstanding. A design that ignores either condition would report completion early.

It also checks three more cases:
- Reads at other offsets and writes to offset 0 must not disturb pending state.
- Clearing the global enable must silence both lines without dropping pending bits.
- The outputs must lag register writes by exactly one edge.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int unsigned NSRC = 6;
  localparam int unsigned DW   = 8;
  localparam int unsigned AW   = 2;

  localparam logic [AW-1:0] OFS_PEND = 2'd0;
  localparam logic [AW-1:0] OFS_MASK = 2'd1;
  localparam logic [AW-1:0] OFS_DEST = 2'd2;
  localparam logic [AW-1:0] OFS_ENA  = 2'd3;

  typedef enum int unsigned {
    SRC_SELECT = 0,
    SRC_DMA    = 1,
    SRC_BUSRST = 2,
    SRC_PARITY = 3,
    SRC_PHASE  = 4,
    SRC_DISC   = 5
  } src_e;
endpackage

// File: rtl/irq_steer_pend.sv
module irq_steer_pend
  import irq_steer_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [N-1:0] evt_i,
  input  logic         dma_rx_i,
  input  logic         buf_empty_i,
  input  logic         hs_busy_i,
  input  logic         clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, pend_d, set_vec;
  logic         defer_q, defer_d;
  logic         drained, dma_now, dma_late;

  assign drained  = buf_empty_i & ~hs_busy_i;
  assign dma_now  = evt_i[SRC_DMA] & (~dma_rx_i | drained);
  assign dma_late = defer_q & drained;

  always_comb begin
    set_vec          = evt_i;
    set_vec[SRC_DMA] = dma_now | dma_late;
    pend_d           = (pend_q & {N{~clr_i}}) | set_vec;
    defer_d          = defer_q;
    if (evt_i[SRC_DMA] && dma_rx_i && !drained) begin
      defer_d = 1'b1;
    end else if (drained) begin
      defer_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pend_q  <= '0;
      defer_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      defer_q <= defer_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int unsigned N = NSRC,
  parameter int unsigned W = DW,
  parameter int unsigned A = AW
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         sel_i,
  input  logic         wr_i,
  input  logic [A-1:0] addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [N-1:0] pend_i,
  output logic [W-1:0] rdata_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] dest_o,
  output logic         en_o,
  output logic         clr_o
);
  localparam int unsigned PAD = W - N;

  logic [N-1:0] mask_q, mask_d, dest_q, dest_d;
  logic         en_q, en_d;
  logic         wr_mask, wr_dest, wr_en;
  logic         unused_wdata;

  assign unused_wdata = ^wdata_i[W-1:N];
  assign wr_mask = sel_i & wr_i & (addr_i == OFS_MASK);
  assign wr_dest = sel_i & wr_i & (addr_i == OFS_DEST);
  assign wr_en   = sel_i & wr_i & (addr_i == OFS_ENA);
  assign clr_o   = sel_i & ~wr_i & (addr_i == OFS_PEND);

  always_comb begin
    mask_d = wr_mask ? wdata_i[N-1:0] : mask_q;
    dest_d = wr_dest ? wdata_i[N-1:0] : dest_q;
    en_d   = wr_en   ? wdata_i[0]     : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mask_q <= '0;
      dest_q <= '0;
      en_q   <= 1'b0;
    end else begin
      mask_q <= mask_d;
      dest_q <= dest_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_PEND: rdata_o = {{PAD{1'b0}}, pend_i};
      OFS_MASK: rdata_o = {{PAD{1'b0}}, mask_q};
      OFS_DEST: rdata_o = {{PAD{1'b0}}, dest_q};
      default:  rdata_o = {{(W-1){1'b0}}, en_q};
    endcase
  end

  assign mask_o = mask_q;
  assign dest_o = dest_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_steer_route.sv
module irq_steer_route
  import irq_steer_pkg::*;
#(
  parameter int unsigned N     = NSRC,
  parameter int unsigned NLINE = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     dest_i,
  input  logic             en_i,
  output logic [NLINE-1:0] irq_o
);
  logic [NLINE-1:0] irq_q, irq_d;

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [N-1:0] pick;
    always_comb begin
      for (int k = 0; k < N; k++) begin
        pick[k] = (int'(dest_i[k]) == g);
      end
      irq_d[g] = en_i & |(pend_i & mask_i & pick);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) irq_q <= '0;
    else          irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_steer.sv
module irq_steer
  import irq_steer_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic [NSRC-1:0] evt_i,
  input  logic            dma_rx_i,
  input  logic            buf_empty_i,
  input  logic            hs_busy_i,
  input  logic            sel_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [1:0]      irq_o
);
  logic [NSRC-1:0] pend_q, mask_q, dest_q;
  logic            en_q, clr;

  irq_steer_pend #(.N(NSRC)) i_pend (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .evt_i(evt_i), .dma_rx_i(dma_rx_i),
    .buf_empty_i(buf_empty_i), .hs_busy_i(hs_busy_i), .clr_i(clr),
    .pend_o(pend_q)
  );

  irq_steer_regs #(.N(NSRC), .W(DW), .A(AW)) i_regs (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .pend_i(pend_q), .rdata_o(rdata_o),
    .mask_o(mask_q), .dest_o(dest_q), .en_o(en_q), .clr_o(clr)
  );

  irq_steer_route #(.N(NSRC), .NLINE(2)) i_route (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .pend_i(pend_q), .mask_i(mask_q),
    .dest_i(dest_q), .en_i(en_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
  import irq_steer_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt,
  input logic            sel,
  input logic            wr,
  input logic [AW-1:0]   addr,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] dest,
  input logic            en,
  input logic [1:0]      irq
);
  localparam logic [NSRC-1:0] NODMA = ~(NSRC'(1) << SRC_DMA);

  logic rd_pend;
  assign rd_pend = sel & ~wr & (addr == OFS_PEND);

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt & NODMA) |=> ((pend & $past(evt & NODMA)) == $past(evt & NODMA))); // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && evt == '0) |=> ((pend & NODMA) == '0)); // R2
  AST_CLEAR_KEEPS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && |(evt & NODMA)) |=> |(pend & NODMA)); // R3
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & mask) == '0) |=> (irq == 2'b00)); // R4
  AST_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    (en && |(pend & mask & ~dest)) |=> irq[0]); // R5
  AST_LINE1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && |(pend & mask & dest)) |=> irq[1]); // R5
  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (irq == 2'b00)); // R6
endmodule

bind irq_steer irq_steer_chk i_chk (
  .clk(clk_i), .rst_n(rst_n_i), .evt(evt_i), .sel(sel_i), .wr(wr_i),
  .addr(addr_i), .pend(pend_q), .mask(mask_q), .dest(dest_q), .en(en_q),
  .irq(irq_o)
);

// File: tb/test_irq_steer.sv
module test_irq_steer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] evt = '0;
  logic       dma_rx = 1'b0, buf_empty = 1'b1, hs_busy = 1'b0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_steer i_irq_steer (
    .clk_i(clk), .rst_n_i(rst_n), .evt_i(evt), .dma_rx_i(dma_rx),
    .buf_empty_i(buf_empty), .hs_busy_i(hs_busy), .sel_i(sel), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #2 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic pulse(input logic [5:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset values
    for (int a = 0; a < 4; a++) begin
      rreg(2'(a), d); chk("R9 reset", d, 8'h00);
    end
    chk("R7 reset irq", {6'b0, irq}, 8'h00);
    // R9 field widths
    wreg(2'd1, 8'hFF); rreg(2'd1, d); chk("R9 mask width", d, 8'h3F);
    wreg(2'd2, 8'hFF); rreg(2'd2, d); chk("R9 dest width", d, 8'h3F);
    wreg(2'd3, 8'hFF); rreg(2'd3, d); chk("R9 enable width", d, 8'h01);
    wreg(2'd3, 8'h00);
    // R1 per-source latch, R2 read clears
    for (int k = 0; k < 6; k++) begin
      pulse(6'(1 << k));
      repeat (2) @(negedge clk);
      rreg(2'd0, d); chk("R1 sticky bit", d, 8'(1 << k));
      rreg(2'd0, d); chk("R2 cleared by read", d, 8'h00);
    end
    // R2 other offsets do not clear; R10 writes to offset 0 ignored
    pulse(6'h09);
    rreg(2'd1, d); rreg(2'd2, d); rreg(2'd3, d);
    wreg(2'd0, 8'h00);
    rreg(2'd0, d); chk("R2 R10 pending kept", d, 8'h09);
    wreg(2'd0, 8'hFF);
    rreg(2'd0, d); chk("R10 write ignored", d, 8'h00);
    // R3 event during clearing read
    pulse(6'h01);
    @(negedge clk); sel = 1; wr = 0; addr = 2'd0; evt = 6'h04;
    #2 d = rdata; chk("R3 read value", d, 8'h01);
    @(negedge clk); sel = 0; evt = '0;
    rreg(2'd0, d); chk("R3 event kept", d, 8'h04);
    // R8 receive DMA completion qualification
    dma_rx = 1; buf_empty = 0; hs_busy = 0;
    pulse(6'h02); repeat (2) @(negedge clk);
    rreg(2'd0, d); chk("R8 held while buffered", d, 8'h00);
    buf_empty = 1; hs_busy = 1; repeat (2) @(negedge clk);
    rreg(2'd0, d); chk("R8 held while handshake", d, 8'h00);
    hs_busy = 0; repeat (2) @(negedge clk);
    rreg(2'd0, d); chk("R8 released when drained", d, 8'h02);
    pulse(6'h02); rreg(2'd0, d); chk("R8 rx drained immediate", d, 8'h02);
    dma_rx = 0; buf_empty = 0;
    pulse(6'h02); rreg(2'd0, d); chk("R8 tx immediate", d, 8'h02);
    buf_empty = 1;
    // R6 global enable off
    pulse(6'h3F);
    wreg(2'd1, 8'h3F); wreg(2'd2, 8'h0F);
    @(negedge clk); chk("R6 disabled", {6'b0, irq}, 8'h00);
    // R7 one-edge latency from enable write
    @(negedge clk); sel = 1; wr = 1; addr = 2'd3; wdata = 8'h01;
    @(negedge clk); sel = 0; wr = 0;
    chk("R7 not yet", {6'b0, irq}, 8'h00);
    @(negedge clk); chk("R7 after one edge", {6'b0, irq}, 8'h03);
    // R4 R5 sweep over mask and steering
    for (int m = 0; m < 64; m++) begin
      for (int s = 0; s < 64; s++) begin
        logic [1:0] e;
        wreg(2'd1, 8'(m)); wreg(2'd2, 8'(s));
        @(negedge clk);
        e[0] = |(6'(m) & ~6'(s));
        e[1] = |(6'(m) & 6'(s));
        chk("R4 R5 routing", {6'b0, irq}, {6'b0, e});
      end
    end
    // R6 disable keeps pending
    wreg(2'd3, 8'h00); @(negedge clk);
    chk("R6 lines low", {6'b0, irq}, 8'h00);
    rreg(2'd0, d); chk("R6 pending kept", d, 8'h3F);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule